// File: doc/BRIEF.md
# Two-Channel PWM Action Qualifier with Continuous Force

This block turns time-base events into two PWM output levels. Each time-base tick it takes the counter value, the counting direction, and the zero and period event flags. It compares the counter with a compare value for each channel. A per-channel action word gives a 2-bit action for each event: hold, drive low, drive high or toggle. The block applies the action of the highest-priority event that has a real action, and the output register updates on that tick.

A continuous force word sits on top of the event logic and can hold either output low or high. The force word arrives as a shadow value. A reload-mode field inside the same word sets when the shadow copy becomes the active force. The choices are the zero tick, the period tick, either of those, or the very next tick. While an active force is set, it overrides every event action on its output. The counter, dead-band, chopping and trip handling all sit outside this block.

Top module: `pwm_action_gen`

## Requirements
- R1: After synchronous reset, both outputs are low and no force is active.
- R2: Outputs and the active force change only on cycles where the time-base tick input is high. Event flags on other cycles have no effect.
- R3: Each 2-bit action code does the following: 00 keeps the output, 01 drives it low, 10 drives it high, 11 inverts it.
- R4: The action word uses these fields:
  - bits 1:0 set the zero-event action.
  - bits 3:2 set the period-event action.
  - Output A takes its compare action from bits 5:4.
  - Output B takes its compare action from bits 9:8.
  - Every other bit is ignored, and so is the other channel's compare field.
- R5: A compare event for a channel occurs only on a tick where the counter equals that channel's compare value and the counter is counting up. A match while counting down has no effect.
- R6: When several events fall on one tick, the output follows one action only. The compare action wins over the period action, and the period action wins over the zero action. An event whose code is 00 does not take part.
- R7: In the force word, bits 1:0 hold output A's force code and bits 3:2 hold output B's. Code 01 forces low and code 10 forces high. Codes 00 and 11 mean no force.
- R8: While an output's active force is low or high, that output takes the forced level on every tick, whatever its event actions say.
- R9: With reload mode 00 in force-word bits 7:6, the shadow force codes become active only on a tick that carries the zero event. That tick's output already uses the new force.
- R10: Reload mode 01 loads on a period tick, mode 10 loads on a zero or a period tick, and mode 11 loads on every tick. So with mode 11, a written force takes over the output at the next tick.
- R11: Output A evaluates compare value A only, and output B evaluates compare value B only.
- R12: Two action-word settings give the standard waveforms:
  - Normal polarity (0x001A for A, 0x010A for B) goes high on zero and period and low on the up-count compare match.
  - Inverted polarity (0x0025 for A, 0x0205 for B) gives the opposite levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | Time-base tick enable |
| tb_up | input | 1 | Counter is counting up |
| tb_count | input | 16 | Time-base counter value |
| tb_zero | input | 1 | Zero event on this tick |
| tb_period | input | 1 | Period event on this tick |
| cmp_val_a | input | 16 | Compare value for output A |
| cmp_val_b | input | 16 | Compare value for output B |
| act_word_a | input | 16 | Action word for output A |
| act_word_b | input | 16 | Action word for output B |
| force_word | input | 16 | Shadow force codes and reload mode |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The embedded properties check the following on every cycle:
- Outputs and the active force hold still between ticks.
- An active low or high force sets the output on the next edge.
- A toggle action inverts the output.
- Immediate reload copies the shadow force codes.

Some behaviours appear only in the bench's directed scenarios:
- Field positions within the action word.
- The priority ordering when events coincide.
- The direction qualification of compare matches.
- The deferred reload modes waiting for the right event.
- The full normal and inverted waveforms over several periods.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int WORD_W    = 16;
    localparam int CODE_W    = 2;
    localparam int ZERO_LSB  = 0;
    localparam int PRD_LSB   = 2;
    localparam int CMPA_LSB  = 4;
    localparam int CMPB_LSB  = 8;
    localparam int RLD_LSB   = 6;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_NONE   = 2'b00,
        FRC_LOW    = 2'b01,
        FRC_HIGH   = 2'b10,
        FRC_NONE2  = 2'b11
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef struct packed {
        logic tick;
        logic up;
        logic zero;
        logic period;
    } tb_evt_t;

    function automatic logic next_level(act_e a, logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    function automatic act_e pick_action(logic cmp_hit, logic prd, logic zro,
                                         act_e c_act, act_e p_act, act_e z_act);
        if (cmp_hit && c_act != ACT_HOLD) return c_act;
        if (prd && p_act != ACT_HOLD)     return p_act;
        if (zro && z_act != ACT_HOLD)     return z_act;
        return ACT_HOLD;
    endfunction

    function automatic logic reload_due(rld_e m, logic zro, logic prd);
        case (m)
            RLD_ZERO:   return zro;
            RLD_PERIOD: return prd;
            RLD_EITHER: return zro | prd;
            default:    return 1'b1;
        endcase
    endfunction

    function automatic logic frc_active(frc_e f);
        return (f == FRC_LOW) || (f == FRC_HIGH);
    endfunction

endpackage

// File: rtl/pwm_aq_cmp_det.sv
module pwm_aq_cmp_det
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  tb_evt_t            evt,
    input  logic [CNT_W-1:0]   count,
    input  logic [CNT_W-1:0]   cmp_val,
    output logic               hit
);
    logic equal;

    always_comb begin
        equal = (count == cmp_val);
        hit   = evt.tick && evt.up && equal;
    end

endmodule

// File: rtl/pwm_aq_force_ctl.sv
module pwm_aq_force_ctl
    import pwm_aq_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  tb_evt_t                   evt,
    input  logic [WORD_W-1:0]         shadow,
    output logic [CODE_W*NUM_CH-1:0]  frc_eff
);
    localparam int FW = CODE_W * NUM_CH;

    logic [FW-1:0] active_q;
    rld_e          mode;
    logic          load;

    always_comb begin
        mode    = rld_e'(shadow[RLD_LSB +: 2]);
        load    = evt.tick && reload_due(mode, evt.zero, evt.period);
        frc_eff = load ? shadow[FW-1:0] : active_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (load) begin
            active_q <= shadow[FW-1:0];
        end
    end

    AST_FRC_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(active_q)); // R2

    AST_FRC_IMM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (evt.tick && mode == RLD_NOW) |=> active_q == $past(shadow[FW-1:0])); // R10

    AST_FRC_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (evt.tick && mode == RLD_ZERO && !evt.zero) |=> $stable(active_q)); // R9

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter int CMP_LSB = CMPA_LSB
) (
    input  logic                clk,
    input  logic                rst,
    input  tb_evt_t             evt,
    input  logic                cmp_hit,
    input  logic [WORD_W-1:0]   act_word,
    input  logic [CODE_W-1:0]   frc_code,
    output logic                pwm
);
    act_e  z_act, p_act, c_act, sel_act;
    frc_e  frc;
    logic  pwm_q, pwm_d;

    always_comb begin
        z_act   = act_e'(act_word[ZERO_LSB +: 2]);
        p_act   = act_e'(act_word[PRD_LSB  +: 2]);
        c_act   = act_e'(act_word[CMP_LSB  +: 2]);
        frc     = frc_e'(frc_code);
        sel_act = pick_action(cmp_hit, evt.period, evt.zero, c_act, p_act, z_act);
        if (frc == FRC_LOW)
            pwm_d = 1'b0;
        else if (frc == FRC_HIGH)
            pwm_d = 1'b1;
        else
            pwm_d = next_level(sel_act, pwm_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
        end else if (evt.tick) begin
            pwm_q <= pwm_d;
        end
    end

    assign pwm = pwm_q;

    AST_OUT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(pwm)); // R2

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
        (evt.tick && frc_code == 2'b01) |=> !pwm); // R8

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (evt.tick && frc_code == 2'b10) |=> pwm); // R8

    AST_TOGGLE_INVERTS: assert property (@(posedge clk) disable iff (rst)
        (evt.tick && !frc_active(frc) && sel_act == ACT_TOGGLE) |=> pwm != $past(pwm)); // R3

endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tb_tick,
    input  logic              tb_up,
    input  logic [CNT_W-1:0]  tb_count,
    input  logic              tb_zero,
    input  logic              tb_period,
    input  logic [CNT_W-1:0]  cmp_val_a,
    input  logic [CNT_W-1:0]  cmp_val_b,
    input  logic [WORD_W-1:0] act_word_a,
    input  logic [WORD_W-1:0] act_word_b,
    input  logic [WORD_W-1:0] force_word,
    output logic              pwm_a,
    output logic              pwm_b
);
    localparam int NUM_CH = 2;

    tb_evt_t                   evt;
    logic [CNT_W-1:0]          cmp_arr [NUM_CH];
    logic [WORD_W-1:0]         act_arr [NUM_CH];
    logic [NUM_CH-1:0]         hit;
    logic [NUM_CH-1:0]         pwm_vec;
    logic [CODE_W*NUM_CH-1:0]  frc_eff;

    always_comb begin
        evt.tick   = tb_tick;
        evt.up     = tb_up;
        evt.zero   = tb_tick && tb_zero;
        evt.period = tb_tick && tb_period;
        cmp_arr[0] = cmp_val_a;
        cmp_arr[1] = cmp_val_b;
        act_arr[0] = act_word_a;
        act_arr[1] = act_word_b;
    end

    pwm_aq_force_ctl #(.NUM_CH(NUM_CH)) u_force (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .shadow  (force_word),
        .frc_eff (frc_eff)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int CLSB = (ch == 0) ? CMPA_LSB : CMPB_LSB;

        pwm_aq_cmp_det #(.CNT_W(CNT_W)) u_cmp (
            .evt     (evt),
            .count   (tb_count),
            .cmp_val (cmp_arr[ch]),
            .hit     (hit[ch])
        );

        pwm_aq_channel #(.CMP_LSB(CLSB)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt),
            .cmp_hit  (hit[ch]),
            .act_word (act_arr[ch]),
            .frc_code (frc_eff[ch*CODE_W +: CODE_W]),
            .pwm      (pwm_vec[ch])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

    AST_NO_DOWN_COMPARE: assert property (@(posedge clk) disable iff (rst)
        (tb_tick && !tb_up && !tb_zero && !tb_period && force_word == 16'h0000
         && act_word_a[3:0] == 4'h0) |=> $stable(pwm_a)); // R5

endmodule

// File: tb/pwm_action_gen_tb.sv
module pwm_action_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        tb_tick, tb_up, tb_zero, tb_period;
    logic [15:0] tb_count, cmp_val_a, cmp_val_b, act_word_a, act_word_b, force_word;
    logic        pwm_a, pwm_b;

    pwm_action_gen u_dut (
        .clk(clk), .rst(rst), .tb_tick(tb_tick), .tb_up(tb_up), .tb_count(tb_count),
        .tb_zero(tb_zero), .tb_period(tb_period), .cmp_val_a(cmp_val_a),
        .cmp_val_b(cmp_val_b), .act_word_a(act_word_a), .act_word_b(act_word_b),
        .force_word(force_word), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    logic [15:0] cfg_cmp_a = 0, cfg_cmp_b = 0, cfg_act_a = 0, cfg_act_b = 0, cfg_frc = 0;
    logic        m_a = 0, m_b = 0;
    logic [3:0]  m_frc = 0;
    string       phase = "R1";

    typedef struct { logic a; logic b; string tag; } exp_t;
    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic mdl(logic cur, logic [1:0] f, logic hit, logic zr,
                                 logic pr, logic [15:0] w, int clsb);
        logic [1:0] sel;
        logic [1:0] c;
        if (f == 2'b01) return 1'b0;
        if (f == 2'b10) return 1'b1;
        c = w[clsb +: 2];
        sel = 2'b00;
        if (zr && w[1:0] != 2'b00) sel = w[1:0];
        if (pr && w[3:2] != 2'b00) sel = w[3:2];
        if (hit && c != 2'b00) sel = c;
        case (sel)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic step(input logic t, input logic up, input logic [15:0] cnt,
                        input logic z, input logic p);
        exp_t e;
        logic load;
        logic [3:0] eff;
        @(negedge clk);
        tb_tick = t; tb_up = up; tb_count = cnt; tb_zero = z; tb_period = p;
        cmp_val_a = cfg_cmp_a; cmp_val_b = cfg_cmp_b;
        act_word_a = cfg_act_a; act_word_b = cfg_act_b; force_word = cfg_frc;
        if (t) begin
            case (cfg_frc[7:6])
                2'b00:   load = z;
                2'b01:   load = p;
                2'b10:   load = z | p;
                default: load = 1'b1;
            endcase
            eff = load ? cfg_frc[3:0] : m_frc;
            m_frc = eff;
            m_a = mdl(m_a, eff[1:0], up && cnt == cfg_cmp_a, z, p, cfg_act_a, 4);
            m_b = mdl(m_b, eff[3:2], up && cnt == cfg_cmp_b, z, p, cfg_act_b, 8);
        end
        e.a = m_a; e.b = m_b; e.tag = phase;
        @(posedge clk);
        q.push_back(e);
    endtask

    task automatic run_period(input int n, input int prd);
        for (int k = 0; k < n; k++)
            for (int c = 0; c <= prd; c++)
                step(1'b1, 1'b1, 16'(c), c == 0, c == prd);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pwm_a !== e.a || pwm_b !== e.b) begin
                errors++;
                $display("FAIL %s: pwm_a/pwm_b actual %b%b expected %b%b", e.tag,
                         pwm_a, pwm_b, e.a, e.b);
            end
        end
    end

    initial begin
        for (int w = 0; w < 100000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tb_tick = 0; tb_up = 0; tb_count = 0; tb_zero = 0; tb_period = 0;
        cmp_val_a = 0; cmp_val_b = 0; act_word_a = 0; act_word_b = 0; force_word = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++; // R1 reset state
        if (pwm_a !== 1'b0 || pwm_b !== 1'b0) begin
            errors++;
            $display("FAIL R1: outputs actual %b%b expected 00", pwm_a, pwm_b);
        end

        // R12 / R11 normal polarity, distinct compare values
        phase = "R12_R11 normal";
        cfg_act_a = 16'h001A; cfg_act_b = 16'h010A; cfg_cmp_a = 3; cfg_cmp_b = 5;
        run_period(2, 8);

        phase = "R12 inverted";
        cfg_act_a = 16'h0025; cfg_act_b = 16'h0205;
        run_period(2, 8);

        phase = "R3 toggle";
        cfg_act_a = 16'h0003; cfg_act_b = 16'h000C;
        run_period(3, 4);
        phase = "R3 low-high";
        cfg_act_a = 16'h0002; cfg_act_b = 16'h0001;
        run_period(1, 4);

        // R4 foreign and unused bits ignored
        phase = "R4 fields";
        cfg_act_a = 16'hFFC0; cfg_act_b = 16'hFCF0; cfg_cmp_a = 2; cfg_cmp_b = 2;
        run_period(2, 6);

        // R5 compare only while counting up
        phase = "R5 down";
        cfg_act_a = 16'h0030; cfg_act_b = 16'h0300; cfg_cmp_a = 4; cfg_cmp_b = 4;
        step(1, 0, 4, 0, 0);
        step(1, 0, 4, 0, 0);
        phase = "R5 up";
        step(1, 1, 4, 0, 0);
        step(1, 1, 3, 0, 0);

        // R6 priority among coincident events
        phase = "R6 cmp wins";
        cfg_act_a = 16'h0036; cfg_act_b = 16'h0106; cfg_cmp_a = 8; cfg_cmp_b = 8;
        step(1, 1, 8, 1, 1);
        step(1, 1, 8, 1, 1);
        phase = "R6 period wins";
        cfg_act_a = 16'h0006; cfg_act_b = 16'h0009;
        step(1, 1, 8, 1, 1);
        phase = "R6 zero when others hold";
        cfg_act_a = 16'h0002;
        step(1, 1, 8, 1, 1);

        // R2 no tick, no change
        phase = "R2 no tick";
        cfg_act_a = 16'h0033; cfg_act_b = 16'h030F;
        step(0, 1, 8, 1, 1);
        step(0, 1, 8, 1, 1);
        step(0, 1, 0, 1, 0);

        // R7 code 11 means no force
        phase = "R7 code11";
        cfg_act_a = 16'h001A; cfg_act_b = 16'h010A; cfg_cmp_a = 3; cfg_cmp_b = 5;
        cfg_frc = 16'h00CF;
        run_period(1, 8);

        // R8 / R10 immediate force overrides actions
        phase = "R8_R10 immediate";
        cfg_frc = 16'h00C6;
        run_period(2, 8);
        phase = "R2 force no tick";
        cfg_frc = 16'h00C9;
        step(0, 1, 1, 0, 0);
        phase = "R10 release";
        cfg_frc = 16'h00C0;
        run_period(1, 8);

        // R9 zero-deferred force
        phase = "R9 zero reload";
        cfg_frc = 16'h0001;
        for (int c = 4; c <= 7; c++) step(1, 1, 16'(c), 0, 0);
        step(1, 1, 8, 0, 1);
        run_period(1, 8);
        cfg_frc = 16'h0000;
        run_period(1, 8);

        // R10 period and either
        phase = "R10 period reload";
        cfg_frc = 16'h0048;
        run_period(1, 8);
        phase = "R10 either reload";
        cfg_frc = 16'h0081;
        for (int c = 1; c <= 8; c++) step(1, 1, 16'(c), 0, c == 8);
        cfg_frc = 16'h0080;
        run_period(1, 8);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule